// File: doc/BRIEF.md
# Receive-Frame CRC Gate

This block sits between the frame decoder of a serial command port and the command executor, and it applies the receive-side CRC policy. At the end of every received frame the decoder raises a one-cycle end-of-frame strobe. In that same cycle it presents the decoded command code and a flag that shows whether the received CRC agreed with the locally computed one. The block then decides whether the command may run, keeps a sticky CRC error bit for the status word, and tells the response builder whether the next outgoing frame must be the default reply: the status word followed by conversion data, the same reply a null command would get.

Checking is switched by a plain enable level that comes from the mode configuration and is low out of reset. With checking off, every command runs and the receive path never raises the error bit. With checking on, a failed CRC blocks every command except a register write. A register write still runs when its CRC fails. When the response builder signals that the status word has been shifted out, the error bit clears. If a new failure arrives in that same cycle, the bit stays set.

All pins are plain control and status levels or strobes. The block has no data stream, so it has no valid/ready handshake and applies no back-pressure. The executor must accept a permit pulse in the cycle it appears.

Top module: `crc_cmd_gate`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `exec_pulse`, `crc_err` and `null_reply_sel` are all low.
- R2: With `chk_en` low, every frame-end strobe produces an `exec_pulse` one cycle later, whatever the value of `crc_ok`. `exec_cmd` carries the code from the strobe cycle, and `crc_err` is not set.
- R3: With `chk_en` high and `crc_ok` high at the strobe, the command executes one cycle later with its code on `exec_cmd`.
- R4: With `chk_en` high and `crc_ok` low at the strobe, any command other than the register write (code 3'b111) produces no `exec_pulse` in the next cycle.
- R5: A register write (code 3'b111) produces an `exec_pulse` one cycle after its strobe, even when checking is on and the CRC has failed.
- R6: A failed check (strobe, `chk_en` high, `crc_ok` low) sets `crc_err` in the next cycle. The bit then stays set until a clear.
- R7: A `status_sent` pulse with no failure in the same cycle clears `crc_err` in the next cycle.
- R8: When a failure and `status_sent` fall in the same cycle, `crc_err` is high in the next cycle.
- R9: At each strobe, `null_reply_sel` loads whether that frame failed, and the new value appears one cycle later. Between strobes it holds its value.
- R10: `exec_pulse` is high only in the cycle directly after a frame-end strobe.
- R11: Command codes are 3 bits: 3'b000 null, 3'b001 reset, 3'b010 standby, 3'b011 wakeup, 3'b100 lock, 3'b101 unlock, 3'b110 register read, 3'b111 register write. `exec_cmd` reproduces the code exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_en | input | 1 | Receive CRC checking enable level |
| frame_end | input | 1 | One-cycle end-of-frame strobe |
| cmd_code | input | 3 | Decoded command code, valid with `frame_end` |
| crc_ok | input | 1 | Received CRC matched, valid with `frame_end` |
| status_sent | input | 1 | Status word has been shifted out |
| exec_pulse | output | 1 | One-cycle permit for the executor |
| exec_cmd | output | 3 | Command code for the permitted command |
| crc_err | output | 1 | Sticky CRC error status bit |
| null_reply_sel | output | 1 | Next response is the default status-plus-data reply |

## Verification
Every result of this block is due exactly one clock edge after the inputs that cause it: the permit and its code, the error bit, and the reply select. No output responds combinationally. The bench drives one set of inputs on the falling edge and lets one rising edge pass. Between that edge and the next falling edge it compares all outputs against a reference model, which it advances by that same single step. Before any stimulus that differs, it checks the hold cases: the select between strobes, the error bit with no clear, and no permit without a strobe.

// File: rtl/cgate_pkg.sv
package cgate_pkg;
  localparam int CMD_W = 3;

  typedef enum logic [CMD_W-1:0] {
    CMD_NULL    = 3'b000,
    CMD_RESET   = 3'b001,
    CMD_STANDBY = 3'b010,
    CMD_WAKEUP  = 3'b011,
    CMD_LOCK    = 3'b100,
    CMD_UNLOCK  = 3'b101,
    CMD_RREG    = 3'b110,
    CMD_WREG    = 3'b111
  } cmd_e;
endpackage

// File: rtl/cgate_verdict.sv
module cgate_verdict #(
  parameter int CMD_W = 3,
  parameter logic [CMD_W-1:0] WR_CODE = '1
) (
  input  logic             frame_end,
  input  logic             chk_en,
  input  logic             crc_ok,
  input  logic [CMD_W-1:0] cmd_code,
  output logic             frame_fail,
  output logic             permit
);
  logic is_write;

  always_comb begin
    is_write   = (cmd_code == WR_CODE);
    frame_fail = frame_end && chk_en && !crc_ok;
    permit     = frame_end && (!frame_fail || is_write);
  end
endmodule

// File: rtl/cgate_sticky.sv
module cgate_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o); // R6
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_o); // R7
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && set_i) |=> flag_o); // R8
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(flag_o)); // R6
endmodule

// File: rtl/cgate_launch.sv
module cgate_launch #(
  parameter int CMD_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_end,
  input  logic             permit,
  input  logic             frame_fail,
  input  logic [CMD_W-1:0] cmd_code,
  output logic             exec_pulse,
  output logic [CMD_W-1:0] exec_cmd,
  output logic             null_sel
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exec_pulse <= 1'b0;
      exec_cmd   <= '0;
      null_sel   <= 1'b0;
    end else begin
      exec_pulse <= permit;
      if (permit)    exec_cmd <= cmd_code;
      if (frame_end) null_sel <= frame_fail;
    end
  end

  AST_PULSE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    exec_pulse |-> $past(frame_end)); // R10
  AST_NULL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (null_sel == $past(frame_fail))); // R9
  AST_NULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(null_sel)); // R9
endmodule

// File: rtl/crc_cmd_gate.sv
module crc_cmd_gate #(
  parameter int CMD_W = cgate_pkg::CMD_W,
  parameter logic [CMD_W-1:0] WR_CODE = CMD_W'(cgate_pkg::CMD_WREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chk_en,
  input  logic             frame_end,
  input  logic [CMD_W-1:0] cmd_code,
  input  logic             crc_ok,
  input  logic             status_sent,
  output logic             exec_pulse,
  output logic [CMD_W-1:0] exec_cmd,
  output logic             crc_err,
  output logic             null_reply_sel
);
  logic frame_fail;
  logic permit;

  cgate_verdict #(.CMD_W(CMD_W), .WR_CODE(WR_CODE)) u_verdict (
    .frame_end (frame_end),
    .chk_en    (chk_en),
    .crc_ok    (crc_ok),
    .cmd_code  (cmd_code),
    .frame_fail(frame_fail),
    .permit    (permit)
  );

  cgate_sticky u_sticky (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (frame_fail),
    .clr_i (status_sent),
    .flag_o(crc_err)
  );

  cgate_launch #(.CMD_W(CMD_W)) u_launch (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_end (frame_end),
    .permit    (permit),
    .frame_fail(frame_fail),
    .cmd_code  (cmd_code),
    .exec_pulse(exec_pulse),
    .exec_cmd  (exec_cmd),
    .null_sel  (null_reply_sel)
  );

  AST_OFF_ALL_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !chk_en) |=> (exec_pulse && exec_cmd == $past(cmd_code))); // R2
  AST_OK_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && crc_ok) |=> exec_pulse); // R3
  AST_BAD_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && chk_en && !crc_ok && cmd_code != WR_CODE) |=> !exec_pulse); // R4
  AST_WRITE_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && cmd_code == WR_CODE) |=> exec_pulse); // R5
  AST_OFF_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!chk_en && !crc_err) |=> !crc_err); // R2
endmodule

// File: tb/tb_crc_cmd_gate.sv
module tb_crc_cmd_gate;
  localparam int CW = 3;
  localparam logic [CW-1:0] WR = 3'b111;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chk_en = 1'b0, frame_end = 1'b0, crc_ok = 1'b0, status_sent = 1'b0;
  logic [CW-1:0] cmd_code = '0;
  logic exec_pulse, crc_err, null_reply_sel;
  logic [CW-1:0] exec_cmd;

  int n_checks = 0;
  int n_errs = 0;
  bit finished = 1'b0;

  // reference model state
  logic m_err = 1'b0, m_null = 1'b0, m_exec = 1'b0;
  logic [CW-1:0] m_cmd = '0;

  always #10 clk = ~clk;

  crc_cmd_gate dut (
    .clk(clk), .rst_n(rst_n), .chk_en(chk_en), .frame_end(frame_end),
    .cmd_code(cmd_code), .crc_ok(crc_ok), .status_sent(status_sent),
    .exec_pulse(exec_pulse), .exec_cmd(exec_cmd), .crc_err(crc_err),
    .null_reply_sel(null_reply_sel)
  );

  function automatic logic f_fail(logic fe, logic en, logic ok);
    return fe && en && !ok;
  endfunction

  function automatic logic f_permit(logic fe, logic en, logic ok, logic [CW-1:0] c);
    return fe && (!f_fail(fe, en, ok) || c == WR);
  endfunction

  function automatic string f_exec_tag(logic fe, logic en, logic ok, logic [CW-1:0] c);
    if (!fe) return "R10";
    if (!en) return "R2";
    if (ok) return "R3";
    if (c == WR) return "R5";
    return "R4";
  endfunction

  function automatic string f_err_tag(logic fl, logic ss);
    if (fl && ss) return "R8";
    if (ss) return "R7";
    return "R6";
  endfunction

  task automatic check(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic fe, input logic [CW-1:0] c, input logic ok,
                      input logic en, input logic ss);
    logic fl;
    @(negedge clk);
    frame_end = fe; cmd_code = c; crc_ok = ok; chk_en = en; status_sent = ss;
    fl = f_fail(fe, en, ok);
    m_exec = f_permit(fe, en, ok, c);
    if (m_exec) m_cmd = c;
    if (fl) m_err = 1'b1;
    else if (ss) m_err = 1'b0;
    if (fe) m_null = fl;
    @(posedge clk);
    #5;
    check(f_exec_tag(fe, en, ok, c), "exec_pulse", 8'(exec_pulse), 8'(m_exec));
    if (m_exec) check("R11", "exec_cmd", 8'(exec_cmd), 8'(m_cmd));
    check(f_err_tag(fl, ss), "crc_err", 8'(crc_err), 8'(m_err));
    check("R9", "null_reply_sel", 8'(null_reply_sel), 8'(m_null));
  endtask

  initial begin
    #(20 * 20000);
    if (!finished) begin
      n_errs++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1", "exec_pulse in reset", 8'(exec_pulse), 8'd0);
    check("R1", "crc_err in reset", 8'(crc_err), 8'd0);
    check("R1", "null_reply_sel in reset", 8'(null_reply_sel), 8'd0);
    rst_n = 1'b1;
    @(posedge clk); #5;
    check("R1", "crc_err after reset", 8'(crc_err), 8'd0);
    check("R1", "exec_pulse after reset", 8'(exec_pulse), 8'd0);

    // directed corner cases
    step(1'b1, 3'b001, 1'b0, 1'b0, 1'b0); // R2: disabled, bad crc still runs
    step(1'b0, 3'b000, 1'b0, 1'b1, 1'b0); // R10: no strobe
    step(1'b1, 3'b100, 1'b1, 1'b1, 1'b0); // R3
    step(1'b1, 3'b110, 1'b0, 1'b1, 1'b0); // R4 + R6 + R9
    step(1'b0, 3'b000, 1'b1, 1'b1, 1'b0); // hold
    step(1'b1, WR,     1'b0, 1'b1, 1'b0); // R5
    step(1'b0, 3'b000, 1'b1, 1'b1, 1'b1); // R7 clear
    step(1'b1, 3'b011, 1'b0, 1'b1, 1'b1); // R8 set beats clear
    step(1'b1, 3'b000, 1'b1, 1'b1, 1'b0); // R9 select drops
    step(1'b0, 3'b000, 1'b0, 1'b0, 1'b1); // R7

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic fe, ok, en, ss;
      logic [CW-1:0] c;
      fe = ($urandom_range(0, 2) == 0);
      c  = CW'($urandom_range(0, 7));
      ok = ($urandom_range(0, 2) != 0);
      en = ($urandom_range(0, 3) != 0);
      ss = ($urandom_range(0, 4) == 0);
      step(fe, c, ok, en, ss);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule